// File: doc/BRIEF.md
# Write-Zero-Clear Interrupt Flag Bank

This block holds the interrupt flags and enable bits of a small microcontroller and presents them through a byte-wide register port. Hardware event inputs set flags on their rising edge. Software clears peripheral flags by writing a byte that has a zero in each position to clear and ones everywhere else. A written one never touches a flag, so a byte-wide read-modify-write cannot wipe out an event that arrives between the read and the write.

Seven interrupt lines each have a line flag and a line enable. Two of the lines are shared. Four timing and transfer sub-sources (transfer busy, one-second tick, one-minute tick, alarm) feed line 6. Four pulse sub-sources (X, Y, W, V) feed line 2. Each sub-source has its own flag and its own enable. A line flag clears in the cycle after the controller acknowledges that line's vector. The block drives one request per line toward an external priority resolver.

Top module: `irqFlagBank`

## Requirements
- R1: After reset every flag, every enable and every bit of `irqReq` is zero.
- R2: A rising edge on an event input sets its flag at the next clock edge. The flag then stays set until a software write or a vector acknowledge clears it.
- R3: An event input that stays high sets its flag only once. After software clears that flag, it stays clear until the input falls and rises again.
- R4: A write to a sub-source flag register (address 2: bit0 transfer, bit1 one-second, bit2 one-minute, bit3 alarm; address 4: bit0 X, bit1 Y, bit2 W, bit3 V) clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R5: When a hardware set and a software clear reach the same sub-source flag in the same cycle, the flag ends up set.
- R6: The line flags (address 0, bit k = line k) ignore register writes. Asserting `vecAck[k]` for one cycle clears line flag k at the next edge.
- R7: `irqReq[k]` is high exactly when line flag k and line enable k (address 1, bit k, read/write) are both set.
- R8: Line flag 6 becomes set one cycle after any timing sub-source flag is set together with its enable (address 3, same bit map as address 2). Line flag 2 behaves the same way for the pulse sub-sources (enables at address 5).
- R9: An acknowledge cannot clear a line flag in a cycle where that line is also being set. This covers an external event edge, and for lines 2 and 6 any enabled sub-source flag that is still pending.
- R10: Reads return the current register contents. Bit positions that are not implemented read as zero, and addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address for read and write |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| extEvent | input | 7 | Event inputs of the seven lines |
| tmrEvent | input | 4 | Timing and transfer sub-source events |
| pulseEvent | input | 4 | Pulse sub-source events |
| vecAck | input | 7 | Vector acknowledge, one bit per line |
| irqReq | output | 7 | Request per line to the priority resolver |

## Verification
A lost set or a spurious clear in any flag register appears on `regRdData` as soon as that register is read. For the line flags it also appears on `irqReq` one cycle after the faulty edge, once the line is enabled. A broken shared-line funnel shows up two edges after a sub-source event: one edge to capture the sub-source flag and one to raise the line flag. The bench reads back each register after every stimulus and watches `irqReq` after each enable or acknowledge, so a fault shows up within a few cycles of its cause.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int NUM_LINES = 7;
  localparam int SUB_W     = 4;
  localparam int XFER_LINE = 6;
  localparam int PULSE_LINE = 2;

  localparam logic [ADDR_W-1:0] ADR_LINE_FLAG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LINE_EN    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_TMR_FLAG   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TMR_EN     = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PULSE_FLAG = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_PULSE_EN   = 3'd5;

  typedef enum logic [2:0] {
    RD_NONE, RD_LINE_FLAG, RD_LINE_EN, RD_TMR_FLAG, RD_TMR_EN, RD_PULSE_FLAG, RD_PULSE_EN
  } rdSel_t;

  typedef struct packed {
    logic   wrLineEn;
    logic   wrTmrFlag;
    logic   wrTmrEn;
    logic   wrPulseFlag;
    logic   wrPulseEn;
    rdSel_t rdSel;
  } bankStb_t;
endpackage

// File: rtl/irqbank_ctrl.sv
module irqbank_ctrl
  import irqbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output bankStb_t          stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    unique case (regAddr)
      ADR_LINE_FLAG:  stb.rdSel = RD_LINE_FLAG;
      ADR_LINE_EN:    begin stb.rdSel = RD_LINE_EN;    stb.wrLineEn    = regWrEn; end
      ADR_TMR_FLAG:   begin stb.rdSel = RD_TMR_FLAG;   stb.wrTmrFlag   = regWrEn; end
      ADR_TMR_EN:     begin stb.rdSel = RD_TMR_EN;     stb.wrTmrEn     = regWrEn; end
      ADR_PULSE_FLAG: begin stb.rdSel = RD_PULSE_FLAG; stb.wrPulseFlag = regWrEn; end
      ADR_PULSE_EN:   begin stb.rdSel = RD_PULSE_EN;   stb.wrPulseEn   = regWrEn; end
      default:        stb.rdSel = RD_NONE;
    endcase
  end

  // R4 / R6: a single write touches at most one register, and only when requested
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrLineEn, stb.wrTmrFlag, stb.wrTmrEn, stb.wrPulseFlag, stb.wrPulseEn}));
  assert_no_write_without_en_R6: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> ({stb.wrLineEn, stb.wrTmrFlag, stb.wrTmrEn, stb.wrPulseFlag, stb.wrPulseEn} == '0));
endmodule

// File: rtl/irqbank_dp.sv
module irqbank_dp
  import irqbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStb_t             stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] extEvent,
  input  logic [SUB_W-1:0]     tmrEvent,
  input  logic [SUB_W-1:0]     pulseEvent,
  input  logic [NUM_LINES-1:0] vecAck,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LINES-1:0] irqReq
);
  logic [NUM_LINES-1:0] extPrev, extRise, lineFlag, lineEn, lineSet;
  logic [SUB_W-1:0]     tmrPrev, tmrRise, tmrFlag, tmrEn;
  logic [SUB_W-1:0]     pulsePrev, pulseRise, pulseFlag, pulseEn;
  logic                 tmrAny, pulseAny;
  logic                 unusedWrHigh;

  assign unusedWrHigh = ^wrData[DATA_W-1:NUM_LINES];

  assign extRise   = extEvent & ~extPrev;
  assign tmrRise   = tmrEvent & ~tmrPrev;
  assign pulseRise = pulseEvent & ~pulsePrev;
  assign tmrAny    = |(tmrFlag & tmrEn);
  assign pulseAny  = |(pulseFlag & pulseEn);

  always_comb begin
    lineSet = extRise;
    lineSet[XFER_LINE]  = lineSet[XFER_LINE] | tmrAny;
    lineSet[PULSE_LINE] = lineSet[PULSE_LINE] | pulseAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev   <= '0;
      tmrPrev   <= '0;
      pulsePrev <= '0;
      lineFlag  <= '0;
      lineEn    <= '0;
      tmrFlag   <= '0;
      tmrEn     <= '0;
      pulseFlag <= '0;
      pulseEn   <= '0;
    end else begin
      extPrev   <= extEvent;
      tmrPrev   <= tmrEvent;
      pulsePrev <= pulseEvent;
      lineFlag  <= (lineFlag & ~vecAck) | lineSet;
      tmrFlag   <= (stb.wrTmrFlag ? (tmrFlag & wrData[SUB_W-1:0]) : tmrFlag) | tmrRise;
      pulseFlag <= (stb.wrPulseFlag ? (pulseFlag & wrData[SUB_W-1:0]) : pulseFlag) | pulseRise;
      if (stb.wrLineEn)  lineEn  <= wrData[NUM_LINES-1:0];
      if (stb.wrTmrEn)   tmrEn   <= wrData[SUB_W-1:0];
      if (stb.wrPulseEn) pulseEn <= wrData[SUB_W-1:0];
    end
  end

  assign irqReq = lineFlag & lineEn;

  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      RD_LINE_FLAG:  rdData[NUM_LINES-1:0] = lineFlag;
      RD_LINE_EN:    rdData[NUM_LINES-1:0] = lineEn;
      RD_TMR_FLAG:   rdData[SUB_W-1:0]     = tmrFlag;
      RD_TMR_EN:     rdData[SUB_W-1:0]     = tmrEn;
      RD_PULSE_FLAG: rdData[SUB_W-1:0]     = pulseFlag;
      RD_PULSE_EN:   rdData[SUB_W-1:0]     = pulseEn;
      default:       rdData = '0;
    endcase
  end

  // R2: without a write, no timing sub-source flag drops
  assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrTmrFlag |=> (($past(tmrFlag) & ~tmrFlag) == '0));
  // R4: a written one keeps a set flag
  assert_one_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrTmrFlag |=> (($past(tmrFlag) & $past(wrData[SUB_W-1:0]) & ~tmrFlag) == '0));
  // R5: an edge always lands, even against a clearing write
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|pulseRise) |=> (($past(pulseRise) & ~pulseFlag) == '0));
  // R6: line flags fall only after an acknowledge
  assert_ack_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck == '0) |=> (($past(lineFlag) & ~lineFlag) == '0));
  // R9: a pending enabled sub-source keeps the shared line flag set
  assert_shared_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    tmrAny |=> lineFlag[XFER_LINE]);
endmodule

// File: rtl/irqFlagBank.sv
module irqFlagBank
  import irqbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_LINES-1:0] extEvent,
  input  logic [SUB_W-1:0]     tmrEvent,
  input  logic [SUB_W-1:0]     pulseEvent,
  input  logic [NUM_LINES-1:0] vecAck,
  output logic [NUM_LINES-1:0] irqReq
);
  bankStb_t stb;

  irqbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .stb(stb)
  );

  irqbank_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .extEvent(extEvent), .tmrEvent(tmrEvent), .pulseEvent(pulseEvent),
    .vecAck(vecAck), .rdData(regRdData), .irqReq(irqReq)
  );
endmodule

// File: tb/irqFlagBank_bench.sv
`timescale 1ns/1ps
module irqFlagBank_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [6:0] extEvent = '0;
  logic [3:0] tmrEvent = '0;
  logic [3:0] pulseEvent = '0;
  logic [6:0] vecAck = '0;
  logic [6:0] irqReq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    bit         isIrq;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  irqFlagBank u_irqFlagBank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .extEvent(extEvent),
    .tmrEvent(tmrEvent), .pulseEvent(pulseEvent), .vecAck(vecAck), .irqReq(irqReq)
  );

  // monitor: pops expected items and compares them away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbQ.pop_front();
        act = it.isIrq ? {1'b0, irqReq} : regRdData;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expectRd(logic [2:0] a, logic [7:0] e, string tag);
    regAddr = a;
    sbQ.push_back('{1'b0, e, tag});
    @(negedge clk);
    #0.5;
  endtask

  task automatic expectIrq(logic [6:0] e, string tag);
    sbQ.push_back('{1'b1, {1'b0, e}, tag});
    @(negedge clk);
    #0.5;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    for (int a = 0; a < 6; a++) expectRd(3'(a), 8'h00, "R1 reset register");
    expectIrq(7'h00, "R1 reset irqReq");

    // R2 edge sets timing flag
    step(); tmrEvent = 4'b0001;
    step();
    expectRd(3'd2, 8'h01, "R2 transfer flag set by edge");
    expectIrq(7'h00, "R7 no request without enables");

    // R3 held level does not re-set after clear
    step(); wr(3'd2, 8'hFE);
    step();
    expectRd(3'd2, 8'h00, "R3 cleared flag stays clear under held level");
    step(); tmrEvent = 4'b0000;
    step(); tmrEvent = 4'b0001;
    step();
    expectRd(3'd2, 8'h01, "R3 new edge sets again");

    // R4 write-zero-clear, write-one-keep
    step(); tmrEvent = 4'b1111;
    step();
    expectRd(3'd2, 8'h0F, "R2 all timing flags set");
    step(); wr(3'd2, 8'hFF);
    step();
    expectRd(3'd2, 8'h0F, "R4 written ones keep flags");
    step(); wr(3'd2, 8'hF5);
    step();
    expectRd(3'd2, 8'h05, "R4 zeros clear bits 1 and 3 only");
    tmrEvent = 4'b0000;
    step(4);
    expectRd(3'd2, 8'h05, "R2 flags persist while idle");

    // R8 shared line 6 funnel
    expectRd(3'd0, 8'h00, "R8 no line flag without sub enable");
    step(); wr(3'd3, 8'h04);
    step();
    expectRd(3'd0, 8'h40, "R8 line 6 set from enabled one-minute flag");
    step(); wr(3'd1, 8'h40);
    step();
    expectIrq(7'h40, "R7 line 6 request with enable");
    expectRd(3'd1, 8'h40, "R10 line enable reads back");

    // R9 ack against pending sub-source
    step(); vecAck = 7'h40;
    step(); vecAck = 7'h00;
    step();
    expectRd(3'd0, 8'h40, "R9 ack ignored while sub-source pending");
    step(); wr(3'd2, 8'h00);
    step(); vecAck = 7'h40;
    step(); vecAck = 7'h00;
    step();
    expectRd(3'd0, 8'h00, "R6 ack clears line 6");
    expectIrq(7'h00, "R7 request drops with flag");

    // R6 external line flags ignore writes, clear on ack
    step(); extEvent = 7'h01;
    step(); extEvent = 7'h00;
    step();
    expectRd(3'd0, 8'h01, "R2 external line 0 set");
    step(); wr(3'd0, 8'h00);
    step();
    expectRd(3'd0, 8'h01, "R6 write does not clear line flag");
    step(); vecAck = 7'h01;
    step(); vecAck = 7'h00;
    step();
    expectRd(3'd0, 8'h00, "R6 ack clears line 0");

    // R5 set wins against same-cycle clear
    step();
    pulseEvent = 4'b0010; regAddr = 3'd4; regWrData = 8'h00; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0; pulseEvent = 4'b0000;
    step();
    expectRd(3'd4, 8'h02, "R5 set beats clearing write");

    // R8 pulse funnel to line 2
    step(); wr(3'd5, 8'h02);
    step();
    expectRd(3'd0, 8'h04, "R8 line 2 set from enabled Y pulse");
    step(); wr(3'd1, 8'h44);
    step();
    expectIrq(7'h04, "R7 line 2 request");

    // R9 event edge beats ack on external line
    step(); extEvent = 7'h08;
    step(); extEvent = 7'h00;
    step(); extEvent = 7'h08; vecAck = 7'h08;
    step(); vecAck = 7'h00; extEvent = 7'h00;
    step();
    expectRd(3'd0, 8'h0C, "R9 edge beats ack on line 3");
    step(); wr(3'd1, 8'h4C);
    step();
    expectIrq(7'h0C, "R7 lines 2 and 3 request");

    // R10 unmapped addresses and unused bits
    expectRd(3'd6, 8'h00, "R10 address 6 reads zero");
    expectRd(3'd7, 8'h00, "R10 address 7 reads zero");
    step(); wr(3'd3, 8'hFF);
    step();
    expectRd(3'd3, 8'h0F, "R10 unused enable bits read zero");

    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule